// File: doc/BRIEF.md
# Reset-Time Programming-Mode Strap Controller

This block chooses, once per power-up, between normal user operation and an in-circuit programming mode. It makes the choice from the level of a single shared pad. In user operation that pad is an output only. While the block's own power-on reset window runs, the pad is released: its driver is off and its weak pull-up is on, so an external programmer can hold it low. The window length is set in clock cycles by `porLen`. With the default counter width and a 250 MHz clock, it can span the full 2.5 ms to 10 ms range.

The pad passes through a two-flop synchronizer. A sticky qualification flag is cleared by any synchronized high seen in the window. When the window counter expires, the block latches programming mode only if the flag is still set and the final sample is low. The choice then holds until `rawRstN` is asserted again.

In user mode the pad is driven from the user port bit. In programming mode the pad becomes an open-drain half-duplex line: the serial engine pulls it low through the output enable, and the synchronized pad level is returned to it. Programming mode also halts the CPU, disables the peripherals and refreshes an enabled watchdog on every cycle.

Top module: `prog_strap_ctrl`

## Requirements
- R1: While `rawRstN` is low, and for the whole window after it, `porActive` is 1, `padOe` is 0, `padPullup` is 1 and `icpMode` is 0.
- R2: With `porLen` >= 4 held constant, `porActive` is still 1 after rising edge `porLen`-1 following the release of `rawRstN`, and is 0 after rising edge `porLen`.
- R3: If `padIn` is low at every rising edge from 1 to `porLen`-2 after release, `icpMode` is 1 when the window closes.
- R4: If `padIn` is high at any rising edge from 1 to `porLen`-2 after release, the block enters user mode (`icpMode` = 0). A high at edge `porLen`-1 or later has no effect on the decision.
- R5: In user mode, `padOe` is 1, `padOut` equals `userOut`, `padPullup` is 0 and `serRx` is 1.
- R6: In programming mode, `padOut` is 0, `padPullup` is 1 and `padOe` equals `serTxLow`. `serRx` follows `padIn` two rising edges later.
- R7: `cpuHalt` and `periphDisable` are 1 in programming mode and 0 in user mode.
- R8: `wdtRefresh` is 1 exactly when `icpMode` is 1 and `wdtEnable` is 1.
- R9: Once the window has closed, the selected mode does not change on any `padIn` activity until `rawRstN` is asserted again. A new assertion restarts the window and the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rawRstN | input | 1 | Power-on reset from the supply detector, active low, asynchronous |
| porLen | input | CNT_W | Reset window length in clock cycles |
| padIn | input | 1 | Level read from the shared pad |
| userOut | input | 1 | User port bit driven onto the pad in user mode |
| serTxLow | input | 1 | Serial engine request to pull the pad low |
| wdtEnable | input | 1 | Watchdog enabled |
| porActive | output | 1 | Reset window running; chip held in reset |
| padOe | output | 1 | Pad output enable |
| padOut | output | 1 | Pad output value |
| padPullup | output | 1 | Pad weak pull-up enable |
| serRx | output | 1 | Synchronized pad level for the serial engine |
| icpMode | output | 1 | Programming mode latched |
| cpuHalt | output | 1 | Stop instruction execution |
| periphDisable | output | 1 | Disable on-chip peripherals |
| wdtRefresh | output | 1 | Watchdog refresh strobe |

## Verification
The checker assumes that `porLen` stays constant from the release of `rawRstN` until the window closes. Its window-length property compares elapsed cycles against the live value, so a change mid-window would give a false report. It also assumes `porLen` is at least 4, so that the synchronizer has filled before qualification starts. The bench sets `porLen` only while reset is held, uses lengths from 4 to 1000, and changes `padIn`, `userOut`, `serTxLow` and `wdtEnable` only on falling clock edges.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // Strobes from the window control to the pad datapath
  typedef struct packed {
    logic inReset;   // window running, pad released with pull-up
    logic qualEn;    // synchronizer filled, sampled highs clear qualification
    logic icpMode;   // latched programming mode
  } strapStrobe_t;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int CNT_W       = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rawRstN,
  input  logic [CNT_W-1:0] porLen,
  input  logic             lowQualified,
  output strapStrobe_t     strobe
);

  localparam logic [CNT_W-1:0] FILL_CNT = CNT_W'(SYNC_STAGES);

  logic [CNT_W-1:0] winCnt;
  logic             inReset;
  logic             icpLatched;
  logic [CNT_W:0]   nextCnt;
  logic             expire;

  assign nextCnt = {1'b0, winCnt} + 1'b1;
  // porLen of 0 behaves like 1
  assign expire  = nextCnt >= {1'b0, porLen};

  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN) begin
      winCnt     <= '0;
      inReset    <= 1'b1;
      icpLatched <= 1'b0;
    end else if (inReset) begin
      if (expire) begin
        inReset    <= 1'b0;
        icpLatched <= lowQualified;
      end else begin
        winCnt <= nextCnt[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    strobe.inReset = inReset;
    strobe.qualEn  = inReset && (winCnt >= FILL_CNT);
    strobe.icpMode = icpLatched;
  end

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rawRstN,
  input  strapStrobe_t strobe,
  input  logic         padIn,
  input  logic         userOut,
  input  logic         serTxLow,
  input  logic         wdtEnable,
  output logic         lowQualified,
  output logic         padOe,
  output logic         padOut,
  output logic         padPullup,
  output logic         serRx,
  output logic         cpuHalt,
  output logic         periphDisable,
  output logic         wdtRefresh
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncReg;
  logic          syncPin;
  logic          qualify;

  // Reset to ones: an undriven pad reads high through its pull-up
  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN) syncReg <= '1;
    else          syncReg <= {syncReg[LAST-1:0], padIn};
  end

  assign syncPin = syncReg[LAST];

  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN)                     qualify <= 1'b1;
    else if (strobe.qualEn && syncPin) qualify <= 1'b0;
  end

  assign lowQualified = qualify && !syncPin;

  always_comb begin
    if (strobe.inReset) begin
      padOe     = 1'b0;
      padOut    = 1'b0;
      padPullup = 1'b1;
      serRx     = 1'b1;
    end else if (strobe.icpMode) begin
      padOe     = serTxLow;   // open drain: enable only to pull low
      padOut    = 1'b0;
      padPullup = 1'b1;
      serRx     = syncPin;
    end else begin
      padOe     = 1'b1;
      padOut    = userOut;
      padPullup = 1'b0;
      serRx     = 1'b1;
    end
  end

  assign cpuHalt       = strobe.icpMode;
  assign periphDisable = strobe.icpMode;
  assign wdtRefresh    = strobe.icpMode && wdtEnable;

endmodule

// File: rtl/prog_strap_ctrl.sv
module prog_strap_ctrl
  import strap_pkg::*;
#(
  parameter int CNT_W       = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rawRstN,
  input  logic [CNT_W-1:0] porLen,
  input  logic             padIn,
  input  logic             userOut,
  input  logic             serTxLow,
  input  logic             wdtEnable,
  output logic             porActive,
  output logic             padOe,
  output logic             padOut,
  output logic             padPullup,
  output logic             serRx,
  output logic             icpMode,
  output logic             cpuHalt,
  output logic             periphDisable,
  output logic             wdtRefresh
);

  strapStrobe_t strobe;
  logic         lowQualified;

  strap_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk          (clk),
    .rawRstN      (rawRstN),
    .porLen       (porLen),
    .lowQualified (lowQualified),
    .strobe       (strobe)
  );

  strap_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk           (clk),
    .rawRstN       (rawRstN),
    .strobe        (strobe),
    .padIn         (padIn),
    .userOut       (userOut),
    .serTxLow      (serTxLow),
    .wdtEnable     (wdtEnable),
    .lowQualified  (lowQualified),
    .padOe         (padOe),
    .padOut        (padOut),
    .padPullup     (padPullup),
    .serRx         (serRx),
    .cpuHalt       (cpuHalt),
    .periphDisable (periphDisable),
    .wdtRefresh    (wdtRefresh)
  );

  assign porActive = strobe.inReset;
  assign icpMode   = strobe.icpMode;

endmodule

// File: rtl/strap_checker.sv
module strap_checker #(
  parameter int CNT_W = 22
) (
  input logic             clk,
  input logic             rawRstN,
  input logic [CNT_W-1:0] porLen,
  input logic             userOut,
  input logic             serTxLow,
  input logic             wdtEnable,
  input logic             porActive,
  input logic             padOe,
  input logic             padOut,
  input logic             padPullup,
  input logic             icpMode,
  input logic             cpuHalt,
  input logic             periphDisable,
  input logic             wdtRefresh
);

  // Cycles since reset release, saturating
  logic [CNT_W:0] elapsed;
  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN)        elapsed <= '0;
    else if (!(&elapsed)) elapsed <= elapsed + 1'b1;
  end

  AST_RESET_PAD_RELEASED: assert property (@(posedge clk) disable iff (!rawRstN)
    porActive |-> (!padOe && padPullup && !icpMode)); // R1

  AST_WINDOW_OPEN: assert property (@(posedge clk) disable iff (!rawRstN)
    (elapsed < {1'b0, porLen}) |-> porActive); // R2

  AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (!rawRstN)
    ((elapsed >= {1'b0, porLen}) && (porLen != '0)) |-> !porActive); // R2

  AST_USER_PAD_DRIVE: assert property (@(posedge clk) disable iff (!rawRstN)
    (!porActive && !icpMode) |-> (padOe && (padOut == userOut) && !padPullup)); // R5

  AST_ICP_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rawRstN)
    icpMode |-> (!padOut && padPullup && (padOe == serTxLow))); // R6

  AST_ICP_FREEZE: assert property (@(posedge clk) disable iff (!rawRstN)
    icpMode |-> (cpuHalt && periphDisable)); // R7

  AST_USER_RUN: assert property (@(posedge clk) disable iff (!rawRstN)
    (!porActive && !icpMode) |-> (!cpuHalt && !periphDisable)); // R7

  AST_WDT_SERVICE: assert property (@(posedge clk) disable iff (!rawRstN)
    (icpMode && wdtEnable) |-> wdtRefresh); // R8

  AST_WDT_QUIET: assert property (@(posedge clk) disable iff (!rawRstN)
    !(icpMode && wdtEnable) |-> !wdtRefresh); // R8

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rawRstN)
    (!porActive && $past(!porActive)) |-> $stable(icpMode)); // R9

endmodule

bind prog_strap_ctrl strap_checker #(.CNT_W(CNT_W)) u_strapChk (
  .clk           (clk),
  .rawRstN       (rawRstN),
  .porLen        (porLen),
  .userOut       (userOut),
  .serTxLow      (serTxLow),
  .wdtEnable     (wdtEnable),
  .porActive     (porActive),
  .padOe         (padOe),
  .padOut        (padOut),
  .padPullup     (padPullup),
  .icpMode       (icpMode),
  .cpuHalt       (cpuHalt),
  .periphDisable (periphDisable),
  .wdtRefresh    (wdtRefresh)
);

// File: tb/test_prog_strap_ctrl.sv
module test_prog_strap_ctrl;

  localparam int CNT_W = 22;

  logic             clk = 1'b0;
  logic             rawRstN = 1'b0;
  logic [CNT_W-1:0] porLen = CNT_W'(20);
  logic             padIn = 1'b1;
  logic             userOut = 1'b0;
  logic             serTxLow = 1'b0;
  logic             wdtEnable = 1'b0;
  logic porActive, padOe, padOut, padPullup, serRx;
  logic icpMode, cpuHalt, periphDisable, wdtRefresh;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  prog_strap_ctrl #(.CNT_W(CNT_W)) i_prog_strap_ctrl (
    .clk(clk), .rawRstN(rawRstN), .porLen(porLen), .padIn(padIn),
    .userOut(userOut), .serTxLow(serTxLow), .wdtEnable(wdtEnable),
    .porActive(porActive), .padOe(padOe), .padOut(padOut),
    .padPullup(padPullup), .serRx(serRx), .icpMode(icpMode),
    .cpuHalt(cpuHalt), .periphDisable(periphDisable), .wdtRefresh(wdtRefresh)
  );

  // {window length, edge index of a one-edge high pulse (0 none, 255 always high), expected icpMode}
  localparam int NVEC = 14;
  localparam logic [24:0] VEC [NVEC] = '{
    {16'd20,   8'd0,   1'b1},
    {16'd20,   8'd255, 1'b0},
    {16'd20,   8'd1,   1'b0},
    {16'd20,   8'd10,  1'b0},
    {16'd20,   8'd18,  1'b0},
    {16'd20,   8'd19,  1'b1},
    {16'd20,   8'd20,  1'b1},
    {16'd8,    8'd6,   1'b0},
    {16'd8,    8'd7,   1'b1},
    {16'd64,   8'd3,   1'b0},
    {16'd4,    8'd0,   1'b1},
    {16'd4,    8'd2,   1'b0},
    {16'd4,    8'd3,   1'b1},
    {16'd1000, 8'd0,   1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic holdReset(input int len, input logic pinLevel);
    @(negedge clk);
    rawRstN = 1'b0;
    porLen  = CNT_W'(len);
    padIn   = pinLevel;
    repeat (2) @(negedge clk);
  endtask

  // Release reset and walk the window; pulse = edge of a one-edge high
  task automatic runWindow(input int len, input int pulse, input logic expIcp);
    holdReset(len, pulse == 255);
    rawRstN = 1'b1;
    for (int k = 1; k <= len + 3; k++) begin
      padIn = (pulse == 255) || (pulse == k);
      @(posedge clk); #1;
      if (k == len - 1) begin
        chk("R2 porActive before close", porActive, 1);
        chk("R1 pad released in window", {padOe, padPullup}, 2'b01);
      end
      if (k == len) chk("R2 porActive after close", porActive, 0);
      @(negedge clk);
    end
    if (expIcp) chk("R3 low strap enters programming", icpMode, 1);
    else        chk("R4 high sample selects user", icpMode, 0);
    chk("R7 halt and disable follow mode", {cpuHalt, periphDisable}, {expIcp, expIcp});
  endtask

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // Reset state
    holdReset(20, 1'b1);
    #1;
    chk("R1 reset state", {porActive, padOe, padPullup, icpMode}, 4'b1010);

    for (int v = 0; v < NVEC; v++)
      runWindow(int'(VEC[v][24:9]), int'(VEC[v][8:1]), VEC[v][0]);

    // Programming mode pad behaviour
    runWindow(20, 0, 1'b1);
    serTxLow = 1'b1;
    #1 chk("R6 open-drain pulls low", {padOe, padOut, padPullup}, 3'b101);
    @(negedge clk);
    serTxLow = 1'b0;
    #1 chk("R6 open-drain released", {padOe, padOut, padPullup}, 3'b001);
    @(negedge clk);
    padIn = 1'b1;
    @(posedge clk); #1;
    chk("R6 serRx one edge later", serRx, 0);
    @(posedge clk); #1;
    chk("R6 serRx two edges later", serRx, 1);
    @(negedge clk);
    wdtEnable = 1'b1;
    #1 chk("R8 refresh when enabled", wdtRefresh, 1);
    @(negedge clk);
    wdtEnable = 1'b0;
    #1 chk("R8 no refresh when disabled", wdtRefresh, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      padIn = i[0];
    end
    @(posedge clk); #1;
    chk("R9 programming mode locked", icpMode, 1);

    // User mode pad behaviour
    @(negedge clk);
    runWindow(20, 255, 1'b0);
    userOut = 1'b1;
    #1 chk("R5 user drive high", {padOe, padOut, padPullup, serRx}, 4'b1101);
    @(negedge clk);
    userOut = 1'b0;
    #1 chk("R5 user drive low", {padOe, padOut, padPullup}, 3'b100);
    wdtEnable = 1'b1;
    #1 chk("R8 no refresh in user mode", wdtRefresh, 0);
    padIn = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9 user mode locked", icpMode, 0);
    chk("R5 pad still user output", {padOe, padPullup}, 2'b10);
    wdtEnable = 1'b0;

    // A fresh reset restarts the decision
    runWindow(12, 0, 1'b1);
    chk("R9 new reset re-decides", icpMode, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule